// File: doc/BRIEF.md
# Table-Driven Two-Road Traffic Light Controller

This block sequences the lamps of a crossing between a north/south road and an east/west road. Its next-state logic is a complete truth table: a small lookup array indexed by the current state and the east/west car sensor returns, for every combination, the following state together with the lamp pattern. The state and the lamp pattern are both registered, so the lamps always show the pattern looked up on the previous clock.

The north/south road is the default: its green lasts at least three states and then waits for an east/west car. When one arrives, the north/south lamp goes yellow, then both roads show red for one cycle, then east/west turns green and stays green while cars keep arriving. When the sensor drops, east/west goes yellow, both roads are red for one cycle, and north/south is green again.

Top module: `traffic_table_fsm`

## Requirements
- R1: Each road's lamp is a 3-bit one-hot code ordered {green, yellow, red}: green = 3'b100, yellow = 3'b010, red = 3'b001. The north/south code is in lamps[5:3] and the east/west code is in lamps[2:0]. At no time are both roads showing something other than red.
- R2: A synchronous reset puts the controller in the first north/south green state, and the lamps read 6'b100001 on the edge that samples reset.
- R3: After north/south green starts, it is shown for at least three consecutive cycles, whatever car_ew does.
- R4: In the third north/south green state, car_ew low keeps north/south green indefinitely.
- R5: East/west green (6'b001100) lasts for as long as car_ew stays high, and is followed by east/west yellow (6'b001010) on the cycle after car_ew is seen low.
- R6: Every yellow (6'b010001 or 6'b001010) is followed by exactly one all-red cycle (6'b001001), after which the other road turns green.
- R7: The lamps are registered: a state change decided on one edge shows on the lamps one clock later.
- R8: In the first and second north/south green states, in yellow and in all-red, car_ew has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| car_ew | input | 1 | East/west car waiting |
| lamps | output | 6 | {north/south G,Y,R, east/west G,Y,R}, registered |

## Verification
The two functions that can land on the same cycle are the minimum north/south green and the east/west request: the bench raises car_ew at the very first green cycle and keeps it high, so the request is pending while the minimum hold still runs, and the scoreboard expects three green cycles before yellow. A second collision is car_ew dropping on the cycle east/west green is entered, judged by expecting exactly one green cycle and then yellow, red and north/south green. A reference model in the driver pushes each expected lamp word, tagged with its requirement, and the monitor compares it one clock after the edge that decides it.

// File: rtl/traffic_table_fsm.sv
module traffic_table_fsm #(
  parameter int LAMP_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              car_ew,
  output logic [LAMP_W-1:0] lamps
);

  localparam int ST_W   = 3;
  localparam int ADDR_W = ST_W + 1;
  localparam int WORDS  = 1 << ADDR_W;
  localparam int WORD_W = ST_W + LAMP_W;

  localparam logic [ST_W-1:0] S_NG1 = 3'd0;
  localparam logic [ST_W-1:0] S_NG2 = 3'd1;
  localparam logic [ST_W-1:0] S_NG3 = 3'd2;
  localparam logic [ST_W-1:0] S_NY  = 3'd3;
  localparam logic [ST_W-1:0] S_NR  = 3'd4;
  localparam logic [ST_W-1:0] S_EG  = 3'd5;
  localparam logic [ST_W-1:0] S_EY  = 3'd6;
  localparam logic [ST_W-1:0] S_ER  = 3'd7;

  localparam logic [2:0] L_G = 3'b100;
  localparam logic [2:0] L_Y = 3'b010;
  localparam logic [2:0] L_R = 3'b001;

  function automatic logic [WORD_W-1:0] entry(input logic [ADDR_W-1:0] a);
    logic [ST_W-1:0] s;
    logic            c;
    s = a[ADDR_W-1:1];
    c = a[0];
    case (s)
      S_NG1:   entry = {S_NG2,                 L_G, L_R};
      S_NG2:   entry = {S_NG3,                 L_G, L_R};
      S_NG3:   entry = {c ? S_NY : S_NG3,      L_G, L_R};
      S_NY:    entry = {S_NR,                  L_Y, L_R};
      S_NR:    entry = {S_EG,                  L_R, L_R};
      S_EG:    entry = {c ? S_EG : S_EY,       L_R, L_G};
      S_EY:    entry = {S_ER,                  L_R, L_Y};
      default: entry = {S_NG1,                 L_R, L_R};
    endcase
  endfunction

  logic [WORD_W-1:0] table_mem [WORDS];
  logic [ST_W-1:0]   st;
  logic [WORD_W-1:0] word;

  always_comb
    for (int i = 0; i < WORDS; i++) table_mem[i] = entry(ADDR_W'(i));

  assign word = table_mem[{st, car_ew}];

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_NG1;
      lamps <= {L_G, L_R};
    end else begin
      st    <= word[WORD_W-1:LAMP_W];
      lamps <= word[LAMP_W-1:0];
    end
  end

  assert_reset_state_R2: assert property (@(posedge clk)
    rst |=> (st == S_NG1 && lamps == {L_G, L_R}));

  assert_onehot_lamps_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot(lamps[5:3]) && $onehot(lamps[2:0]) && (lamps[5:3] == L_R || lamps[2:0] == L_R));

  assert_min_green_a_R3: assert property (@(posedge clk) disable iff (rst)
    (st == S_NG1) |=> (st == S_NG2));

  assert_min_green_b_R3: assert property (@(posedge clk) disable iff (rst)
    (st == S_NG2) |=> (st == S_NG3));

  assert_ns_wait_R4: assert property (@(posedge clk) disable iff (rst)
    (st == S_NG3 && !car_ew) |=> (st == S_NG3));

  assert_ew_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (st == S_EG && car_ew) |=> (st == S_EG));

  assert_yellow_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (lamps == {L_Y, L_R} || lamps == {L_R, L_Y}) |=> (lamps == {L_R, L_R}));

  assert_red_then_green_R6: assert property (@(posedge clk) disable iff (rst)
    (lamps == {L_R, L_R}) |=> (lamps == {L_G, L_R} || lamps == {L_R, L_G}));

  assert_lamp_lag_R7: assert property (@(posedge clk) disable iff (rst)
    (st == S_EG && $past(st) == S_NR) |-> (lamps == {L_R, L_R}));

endmodule

// File: tb/traffic_table_fsm_bench.sv
`timescale 1ns/100ps
module traffic_table_fsm_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       car_ew = 1'b0;
  logic [5:0] lamps;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [5:0] exp_q[$];
  string      tag_q[$];
  int         ms = 0;

  always #2.5 clk = ~clk;

  traffic_table_fsm u_traffic_table_fsm (
    .clk(clk), .rst(rst), .car_ew(car_ew), .lamps(lamps)
  );

  function automatic logic [5:0] pattern(input int s);
    case (s)
      0, 1, 2: pattern = 6'b100001;
      3:       pattern = 6'b010001;
      5:       pattern = 6'b001100;
      6:       pattern = 6'b001010;
      default: pattern = 6'b001001;
    endcase
  endfunction

  function automatic int advance(input int s, input logic c);
    case (s)
      2:       advance = c ? 3 : 2;
      5:       advance = c ? 5 : 6;
      7:       advance = 0;
      default: advance = s + 1;
    endcase
  endfunction

  task automatic step(input logic c, input logic r, input string tag);
    rst    = r;
    car_ew = c;
    if (r) begin
      exp_q.push_back(6'b100001);
      ms = 0;
    end else begin
      exp_q.push_back(pattern(ms));
      ms = advance(ms, c);
    end
    tag_q.push_back(tag);
    @(posedge clk);
    #1;
  endtask

  task automatic run(input logic c, input int n, input string tag);
    for (int i = 0; i < n; i++) step(c, 1'b0, tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [5:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (lamps !== e) begin
        errors++;
        $display("FAIL %s: lamps=%b expected=%b", t, lamps, e);
      end
    end
  end

  initial begin
    step(1'b0, 1'b1, "R2 reset");
    step(1'b1, 1'b1, "R2 reset with car");
    run(1'b1, 3, "R3 minimum green with request");
    run(1'b1, 1, "R7 lamps lag decision");
    run(1'b1, 2, "R6 yellow then all red");
    run(1'b1, 4, "R5 ew green held");
    run(1'b0, 1, "R5 ew yellow after drop");
    run(1'b1, 2, "R8 car ignored in yellow and red");
    run(1'b0, 3, "R1 ns green after clearance");
    run(1'b0, 6, "R4 ns green waits");
    run(1'b1, 1, "R4 request taken");
    run(1'b0, 2, "R8 car low ignored in yellow and red");
    run(1'b0, 1, "R5 single cycle ew green");
    run(1'b1, 1, "R6 ew yellow");
    run(1'b0, 2, "R6 ew all red then ns green");
    step(1'b1, 1'b0, "R8 car in first green");
    step(1'b0, 1'b0, "R8 car low in second green");
    step(1'b1, 1'b0, "R3 third green");
    run(1'b1, 3, "R1 toward ew");
    step(1'b1, 1'b1, "R2 reset during ew green");
    run(1'b0, 4, "R2 after reset");
    run(1'b1, 10, "R1 full cycle");
    run(1'b0, 6, "R1 return");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule